// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the control front end of a dual-loop frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a 24-bit shift register, least significant bit first. When the strobe goes high, shifting stops and the shift-register contents are decoded by the address in the top bits. The word is then written into the matching group of working registers: the main-loop word, the reference/power word, the auxiliary-loop word or the test word. The registered fields drive the dividers, charge-pump gain, comparison selects and lock-detect mode of the surrounding synthesizer.

Three behaviours go beyond a plain register file. First, the compensation-DAC code carried by the reference/power word waits in a shadow register and reaches its output only when the next main-loop word is latched, so it changes together with the main ratio. Second, the charge-pump speed-up enable follows the strobe: it is active for as long as the strobe stays high after a main-loop word, and two test bits can force it on or off. Third, each loop's power state is the exclusive-or of a hardware pin with a software bit, so the pin selects the polarity of the software bit.

The three serial wires pass through a synchronizer whose depth is a parameter (zero stages when the wires are already in the block's clock domain). The block is used by shifting a word, pulsing the strobe, and reading the field outputs.

Top module: `synth_prog_if`

## Requirements
- R1: After reset the outputs are main ratio 1000, fraction increment 0, modulus select 0 (modulo 8), reference ratio 13, lock mode 0, main and aux software power bits 1, compensation-DAC code 80, aux ratio 200, pump gain 0, main and aux comparison selects 0, both test bits 0 and speed-up 0.
- R2: Bits are taken on rising edges of the serial clock while the strobe is low, least significant bit first, so that after 24 edges the last bit sent is bit 23. Bits 23:22 hold the address: 00 selects the main word, 01 the reference/power word, 10 the aux word, and 11 together with bit 21 = 0 selects the test word.
- R3: A main word sets modulus select from bit 21, fraction increment from bits 20:18 and main ratio from bits 17:2; bits 1:0 are spare. In the same cycle the compensation-DAC output takes the value held in the shadow register.
- R4: A reference/power word sets reference ratio from bits 21:12, lock mode from bits 11:10, main power bit from bit 9 and aux power bit from bit 8. Its bits 7:0 go only to the shadow register, and the compensation-DAC output does not change.
- R5: An aux word sets aux ratio from bits 21:8, pump gain from bits 7:6, main comparison select from bits 5:3 and aux comparison select from bits 2:0.
- R6: A test word sets the disable bit from bit 1 and the force bit from bit 0. A word with address bits 23:21 = 111 changes no register, and any word leaves the fields of the other word types unchanged.
- R7: After a main word is latched, speed-up is 1 while the strobe stays high and returns to 0 once the strobe falls. A strobe after any other word type does not raise it.
- R8: When the force bit is 1, speed-up is 1 with no strobe. When the disable bit is 1, speed-up is 0, and this holds even when the force bit is also 1.
- R9: Main power-on equals the power pin XOR the main power bit, and aux power-on equals the pin XOR the aux power bit. With the pin low, a bit value of 1 means on.
- R10: Serial clock edges while the strobe is high do not alter the shift register, so a second strobe with no shifting in between latches the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock from host |
| ser_data | input | 1 | Serial data, LSB first |
| ser_strobe | input | 1 | Latch strobe; high inhibits shifting |
| pwr_pin | input | 1 | Hardware power polarity pin |
| main_ratio | output | 16 | Main divider integer ratio |
| frac_inc | output | 3 | Fractional accumulator increment |
| mod5_sel | output | 1 | 1 selects modulo 5, 0 selects modulo 8 |
| ref_ratio | output | 10 | Reference divider ratio |
| lock_mode | output | 2 | Lock-detect output mode |
| fdac_code | output | 8 | Working compensation-DAC code |
| aux_ratio | output | 14 | Auxiliary divider ratio |
| cp_gain | output | 2 | Charge-pump gain code |
| main_cmp_sel | output | 3 | Reference tap for main comparator |
| aux_cmp_sel | output | 3 | Reference tap for aux comparator |
| speedup | output | 1 | Charge-pump speed-up enable |
| main_on | output | 1 | Main loop powered |
| aux_on | output | 1 | Aux loop powered |

## Verification
The bench goes after the shadow ordering: it sends a reference/power word and checks that the DAC output keeps its old value, then sends a main word and checks the new value. A design that loaded the code straight away would show it one word too early. It drives serial clock pulses while the strobe is high and then strobes again with no shifting; a design that kept shifting would latch a different main ratio. It also covers speed-up after each word type and under both test bits together, so a design that lets the force bit win or arms speed-up after a non-main word gives a wrong enable. It sends an all-ones word with address 111, and any register that changes shows a decode that treats it as a test word.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

   // Two-bit word class held in the top address bits.
   typedef enum logic [1:0] {
      KIND_MAIN = 2'b00,
      KIND_REF  = 2'b01,
      KIND_AUX  = 2'b10,
      KIND_EXT  = 2'b11
   } word_kind_e;

   localparam int unsigned ADDR_W = 2;
   localparam int unsigned SPARE_W = 2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_flop
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
         end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdat,
   input  logic              stb,
   output logic [WORD_W-1:0] word,
   output logic              shift_en,
   output logic              latch
);
   logic sclk_q, stb_q;

   assign shift_en = sclk && !sclk_q && !stb;
   assign latch    = stb && !stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         stb_q  <= 1'b0;
         word   <= '0;
      end else begin
         sclk_q <= sclk;
         stb_q  <= stb;
         if (shift_en) word <= {sdat, word[WORD_W-1:1]};
      end
   end
endmodule

// File: rtl/spi_regs.sv
module spi_regs
   import synth_prog_pkg::*;
#(
   parameter int unsigned WORD_W   = 24,
   parameter int unsigned N_W      = 16,
   parameter int unsigned NF_W     = 3,
   parameter int unsigned R_W      = 10,
   parameter int unsigned AUX_W    = 14,
   parameter int unsigned FDAC_W   = 8,
   parameter int unsigned SEL_W    = 3,
   parameter logic [N_W-1:0]    DEF_N    = 16'd1000,
   parameter logic [R_W-1:0]    DEF_R    = 10'd13,
   parameter logic [AUX_W-1:0]  DEF_AUX  = 14'd200,
   parameter logic [FDAC_W-1:0] DEF_FDAC = 8'd80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic [WORD_W-1:0] word,
   output logic              hit_a,
   output logic              hit_c,
   output logic [N_W-1:0]    n_q,
   output logic [NF_W-1:0]   nf_q,
   output logic              mod5_q,
   output logic [R_W-1:0]    r_q,
   output logic [1:0]        lock_q,
   output logic              main_bit,
   output logic              aux_bit,
   output logic [FDAC_W-1:0] fdac_q,
   output logic [AUX_W-1:0]  aux_q,
   output logic [1:0]        cp_q,
   output logic [SEL_W-1:0]  sm_q,
   output logic [SEL_W-1:0]  sa_q,
   output logic              tdis_q,
   output logic              tspu_q
);
   localparam int unsigned TOP  = WORD_W - 1;
   localparam int unsigned BODY = WORD_W - ADDR_W - 1;

   word_kind_e       kind;
   logic             hit_b, hit_d;
   logic [FDAC_W-1:0] fdac_shadow;

   assign kind  = word_kind_e'(word[TOP -: ADDR_W]);
   assign hit_a = latch && (kind == KIND_MAIN);
   assign hit_b = latch && (kind == KIND_REF);
   assign hit_c = latch && (kind == KIND_AUX);
   assign hit_d = latch && (kind == KIND_EXT) && !word[BODY + 1 - 1 + 0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q         <= DEF_N;
         nf_q        <= '0;
         mod5_q      <= 1'b0;
         r_q         <= DEF_R;
         lock_q      <= 2'b00;
         main_bit    <= 1'b1;
         aux_bit     <= 1'b1;
         fdac_q      <= DEF_FDAC;
         fdac_shadow <= DEF_FDAC;
         aux_q       <= DEF_AUX;
         cp_q        <= 2'b00;
         sm_q        <= '0;
         sa_q        <= '0;
         tdis_q      <= 1'b0;
         tspu_q      <= 1'b0;
      end else begin
         if (hit_a) begin
            mod5_q <= word[BODY];
            nf_q   <= word[BODY-1 -: NF_W];
            n_q    <= word[SPARE_W +: N_W];
            fdac_q <= fdac_shadow;
         end
         if (hit_b) begin
            r_q         <= word[BODY -: R_W];
            lock_q      <= word[FDAC_W+2 +: 2];
            main_bit    <= word[FDAC_W+1];
            aux_bit     <= word[FDAC_W];
            fdac_shadow <= word[0 +: FDAC_W];
         end
         if (hit_c) begin
            aux_q <= word[BODY -: AUX_W];
            cp_q  <= word[2*SEL_W +: 2];
            sm_q  <= word[SEL_W +: SEL_W];
            sa_q  <= word[0 +: SEL_W];
         end
         if (hit_d) begin
            tdis_q <= word[1];
            tspu_q <= word[0];
         end
      end
   end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_a,
   input  logic stb,
   input  logic tspu,
   input  logic tdis,
   input  logic pin,
   input  logic main_bit,
   input  logic aux_bit,
   output logic speedup,
   output logic main_on,
   output logic aux_on
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (hit_a)  armed <= 1'b1;
      else if (!stb)   armed <= 1'b0;
   end

   // Disable wins over force; strobe-timed window otherwise.
   assign speedup = !tdis && (tspu || (armed && stb));
   assign main_on = pin ^ main_bit;
   assign aux_on  = pin ^ aux_bit;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned N_W         = 16,
   parameter int unsigned NF_W        = 3,
   parameter int unsigned R_W         = 10,
   parameter int unsigned AUX_W       = 14,
   parameter int unsigned FDAC_W      = 8,
   parameter int unsigned SEL_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_strobe,
   input  logic              pwr_pin,
   output logic [N_W-1:0]    main_ratio,
   output logic [NF_W-1:0]   frac_inc,
   output logic              mod5_sel,
   output logic [R_W-1:0]    ref_ratio,
   output logic [1:0]        lock_mode,
   output logic [FDAC_W-1:0] fdac_code,
   output logic [AUX_W-1:0]  aux_ratio,
   output logic [1:0]        cp_gain,
   output logic [SEL_W-1:0]  main_cmp_sel,
   output logic [SEL_W-1:0]  aux_cmp_sel,
   output logic              speedup,
   output logic              main_on,
   output logic              aux_on
);
   localparam int unsigned A_SUM = 2 + 1 + NF_W + N_W + 2;
   localparam int unsigned B_SUM = 2 + R_W + 2 + 2 + FDAC_W;
   localparam int unsigned C_SUM = 2 + AUX_W + 2 + 2 * SEL_W;

   if (A_SUM != WORD_W) begin : g_bad_main_layout
      initial $fatal(1, "main word fields do not fill WORD_W");
   end
   if (B_SUM != WORD_W) begin : g_bad_ref_layout
      initial $fatal(1, "reference word fields do not fill WORD_W");
   end
   if (C_SUM != WORD_W) begin : g_bad_aux_layout
      initial $fatal(1, "aux word fields do not fill WORD_W");
   end

   logic [2:0]        wires_s;
   logic              sclk_s, sdat_s, strobe_s;
   logic [WORD_W-1:0] word_sr;
   logic              shift_en, latch;
   logic              hit_a, hit_c;
   logic              main_bit, aux_bit, tdis, tspu;

   spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_strobe, ser_data, ser_clk}), .q(wires_s)
   );
   assign {strobe_s, sdat_s, sclk_s} = wires_s;

   spi_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk(sclk_s), .sdat(sdat_s), .stb(strobe_s),
      .word(word_sr), .shift_en(shift_en), .latch(latch)
   );

   spi_regs #(
      .WORD_W(WORD_W), .N_W(N_W), .NF_W(NF_W), .R_W(R_W),
      .AUX_W(AUX_W), .FDAC_W(FDAC_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .latch(latch), .word(word_sr),
      .hit_a(hit_a), .hit_c(hit_c),
      .n_q(main_ratio), .nf_q(frac_inc), .mod5_q(mod5_sel),
      .r_q(ref_ratio), .lock_q(lock_mode), .main_bit(main_bit), .aux_bit(aux_bit),
      .fdac_q(fdac_code), .aux_q(aux_ratio), .cp_q(cp_gain),
      .sm_q(main_cmp_sel), .sa_q(aux_cmp_sel), .tdis_q(tdis), .tspu_q(tspu)
   );

   spi_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .stb(strobe_s),
      .tspu(tspu), .tdis(tdis), .pin(pwr_pin),
      .main_bit(main_bit), .aux_bit(aux_bit),
      .speedup(speedup), .main_on(main_on), .aux_on(aux_on)
   );

   logic unused_shift;
   assign unused_shift = shift_en;
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned FDAC_W = 8,
   parameter int unsigned AUX_W  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strobe_s,
   input logic              hit_a,
   input logic              hit_c,
   input logic              tspu,
   input logic              pwr_pin,
   input logic              main_bit,
   input logic              main_on,
   input logic              speedup,
   input logic [WORD_W-1:0] word_sr,
   input logic [FDAC_W-1:0] fdac_code,
   input logic [AUX_W-1:0]  aux_ratio
);
   // R3: working DAC code moves only right after a main word latch
   assert_fdac_on_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fdac_code) |-> $past(hit_a));

   // R6: aux fields hold unless an aux word is latched
   assert_aux_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_c |=> $stable(aux_ratio));

   // R7: speed-up only inside a strobe window or when forced
   assert_speedup_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      speedup |-> (strobe_s || tspu));

   // R9: a pin change with a steady software bit flips the power state
   assert_pin_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pwr_pin) != pwr_pin) && $stable(main_bit)) |-> (main_on != $past(main_on)));

   // R10: shift register frozen while strobe is high
   assert_no_shift_in_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_s |=> $stable(word_sr));
endmodule

bind synth_prog_if synth_prog_if_chk #(
   .WORD_W(WORD_W), .FDAC_W(FDAC_W), .AUX_W(AUX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .hit_a(hit_a), .hit_c(hit_c),
   .tspu(tspu), .pwr_pin(pwr_pin), .main_bit(main_bit), .main_on(main_on),
   .speedup(speedup), .word_sr(word_sr), .fdac_code(fdac_code), .aux_ratio(aux_ratio)
);

// File: tb/synth_prog_if_test.sv
`timescale 1ns/1ps
module synth_prog_if_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, pwr_pin = 1'b0;
   logic [15:0] main_ratio;
   logic [2:0]  frac_inc;
   logic        mod5_sel;
   logic [9:0]  ref_ratio;
   logic [1:0]  lock_mode;
   logic [7:0]  fdac_code;
   logic [13:0] aux_ratio;
   logic [1:0]  cp_gain;
   logic [2:0]  main_cmp_sel, aux_cmp_sel;
   logic        speedup, main_on, aux_on;

   int vecs = 0;
   int bad  = 0;
   int cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   synth_prog_if uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_strobe(ser_strobe), .pwr_pin(pwr_pin),
      .main_ratio(main_ratio), .frac_inc(frac_inc), .mod5_sel(mod5_sel),
      .ref_ratio(ref_ratio), .lock_mode(lock_mode), .fdac_code(fdac_code),
      .aux_ratio(aux_ratio), .cp_gain(cp_gain), .main_cmp_sel(main_cmp_sel),
      .aux_cmp_sel(aux_cmp_sel), .speedup(speedup), .main_on(main_on), .aux_on(aux_on)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, got %0d cycles, expected < 150000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vecs++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_in(input logic [23:0] w);
      for (int i = 0; i < 24; i++) begin
         @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
         idle(3);
         ser_clk = 1'b1;
         idle(3);
      end
      ser_clk = 1'b0;
      idle(4);
   endtask

   task automatic pulse_strobe(input int hold);
      @(negedge clk); ser_strobe = 1'b1;
      idle(hold);
      ser_strobe = 1'b0;
      idle(8);
   endtask

   task automatic send(input logic [23:0] w);
      shift_in(w);
      pulse_strobe(10);
   endtask

   function automatic logic [23:0] w_main(input logic m5, input logic [2:0] nf, input logic [15:0] n);
      return {2'b00, m5, nf, n, 2'b00};
   endfunction
   function automatic logic [23:0] w_ref(input logic [9:0] r, input logic [1:0] lk,
                                         input logic mb, input logic ab, input logic [7:0] fd);
      return {2'b01, r, lk, mb, ab, fd};
   endfunction
   function automatic logic [23:0] w_aux(input logic [13:0] a, input logic [1:0] cp,
                                         input logic [2:0] sm, input logic [2:0] sa);
      return {2'b10, a, cp, sm, sa};
   endfunction
   function automatic logic [23:0] w_test(input logic dis, input logic frc);
      return {3'b110, 19'd0, dis, frc};
   endfunction

   task automatic t_reset;
      chk("R1 main ratio", main_ratio, 1000);
      chk("R1 frac inc", frac_inc, 0);
      chk("R1 mod5", mod5_sel, 0);
      chk("R1 ref ratio", ref_ratio, 13);
      chk("R1 lock mode", lock_mode, 0);
      chk("R1 fdac", fdac_code, 80);
      chk("R1 aux ratio", aux_ratio, 200);
      chk("R1 cp gain", cp_gain, 0);
      chk("R1 sm/sa", {main_cmp_sel, aux_cmp_sel}, 0);
      chk("R1 speedup", speedup, 0);
      chk("R1 power", {main_on, aux_on}, 2'b11);
   endtask

   task automatic t_main_word;
      send(w_main(1'b1, 3'd5, 16'd40961));
      chk("R2 R3 main ratio", main_ratio, 40961);
      chk("R3 frac inc", frac_inc, 5);
      chk("R3 mod5", mod5_sel, 1);
      chk("R3 fdac from unchanged shadow", fdac_code, 80);
      chk("R6 ref untouched by main word", ref_ratio, 13);
   endtask

   task automatic t_aux_word;
      send(w_aux(14'd12345, 2'd2, 3'd4, 3'd3));
      chk("R5 aux ratio", aux_ratio, 12345);
      chk("R5 cp gain", cp_gain, 2);
      chk("R5 main cmp sel", main_cmp_sel, 4);
      chk("R5 aux cmp sel", aux_cmp_sel, 3);
      chk("R6 main untouched by aux word", main_ratio, 40961);
   endtask

   task automatic t_shadow;
      send(w_ref(10'd1023, 2'd3, 1'b1, 1'b0, 8'd200));
      chk("R4 ref ratio", ref_ratio, 1023);
      chk("R4 lock mode", lock_mode, 3);
      chk("R4 fdac held in shadow", fdac_code, 80);
      chk("R9 main on pin low", main_on, 1);
      chk("R9 aux off pin low", aux_on, 0);
      send(w_main(1'b0, 3'd7, 16'd512));
      chk("R3 fdac moved with main word", fdac_code, 200);
      chk("R3 main ratio low bound", main_ratio, 512);
      chk("R3 mod8", mod5_sel, 0);
   endtask

   task automatic t_power;
      @(negedge clk); pwr_pin = 1'b1;
      @(negedge clk);
      chk("R9 main off pin high", main_on, 0);
      chk("R9 aux on pin high", aux_on, 1);
      pwr_pin = 1'b0;
      @(negedge clk);
      chk("R9 main on pin low again", main_on, 1);
   endtask

   task automatic t_speedup;
      shift_in(w_main(1'b0, 3'd1, 16'd3000));
      @(negedge clk); ser_strobe = 1'b1;
      idle(10);
      chk("R7 speedup during strobe after main", speedup, 1);
      ser_strobe = 1'b0;
      idle(8);
      chk("R7 speedup ends at strobe fall", speedup, 0);
      shift_in(w_aux(14'd128, 2'd1, 3'd0, 3'd1));
      @(negedge clk); ser_strobe = 1'b1;
      idle(10);
      chk("R7 no speedup after aux word", speedup, 0);
      ser_strobe = 1'b0;
      idle(8);
   endtask

   task automatic t_test_bits;
      send(w_test(1'b0, 1'b1));
      chk("R8 force on", speedup, 1);
      send(w_test(1'b1, 1'b1));
      chk("R8 disable beats force", speedup, 0);
      shift_in(w_main(1'b0, 3'd1, 16'd3001));
      @(negedge clk); ser_strobe = 1'b1;
      idle(10);
      chk("R8 disable blocks strobe window", speedup, 0);
      ser_strobe = 1'b0;
      idle(8);
      send(w_test(1'b0, 1'b0));
      chk("R6 test word cleared", speedup, 0);
      chk("R6 main untouched by test word", main_ratio, 3001);
   endtask

   task automatic t_bad_addr;
      send(24'hFFFFFF);
      chk("R6 addr 111 main", main_ratio, 3001);
      chk("R6 addr 111 ref", ref_ratio, 1023);
      chk("R6 addr 111 aux", aux_ratio, 128);
      chk("R6 addr 111 test bits", speedup, 0);
      chk("R6 addr 111 power", {main_on, aux_on}, 2'b10);
   endtask

   task automatic t_strobe_inhibit;
      send(w_main(1'b1, 3'd2, 16'd777));
      @(negedge clk); ser_strobe = 1'b1;
      idle(4);
      for (int i = 0; i < 6; i++) begin
         ser_data = 1'b1; ser_clk = 1'b1; idle(3);
         ser_clk = 1'b0; idle(3);
      end
      ser_strobe = 1'b0;
      idle(8);
      pulse_strobe(10);
      chk("R10 relatch same main ratio", main_ratio, 777);
      chk("R10 relatch same frac inc", frac_inc, 2);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_main_word();
      t_aux_word();
      t_shadow();
      t_power();
      t_speedup();
      t_test_bits();
      t_bad_addr();
      t_strobe_inhibit();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule